// File: doc/BRIEF.md
# Eight-Source Vectored Interrupt Controller

This block sits beside an 8051-class CPU core and decides which of eight interrupt sources is served next. Six of the sources arrive as ready-made request flags: external 0, external 1, three timers and the serial port. Each has its enable and priority bits supplied as plain inputs. The other two are external pins that the block samples itself. Each pin can be set to trigger on a falling edge or on a low level.

One 8-bit control register configures the two sampled pins. Each pin has four bits in it: trigger type, pending flag, enable and priority. The CPU writes the register as a whole byte, or one bit at a time through bit addresses. Every cycle the block takes the enabled pending sources and first picks the level: a high-priority source wins over any low-priority one. Within that level it picks by fixed rank. The winner's index, vector address and level appear on registered outputs. The CPU acknowledges the request it takes and signals the end of each service routine. The block keeps a two-level record of the routines in progress, so that it never offers a request that is not allowed to interrupt the current one.

Top module: `irq8_ctrl`

## Requirements
- R1: During and right after a synchronous reset, the control register reads 00h and no request is presented.
- R2: Source index i has vector address 03h + 8*i. The indices are 0 external 0, 1 timer 0, 2 external 1, 3 timer 1, 4 serial, 5 timer 2, 6 pin A (external 2), 7 pin B (external 3).
- R3: Among the eligible pending sources, a high-priority one always wins over a low-priority one. Within one level, the lowest index wins. The winner's priority shows on `irq_hi`.
- R4: A source is pending only when its own enable bit and `glb_en` are both 1. Six-source enables are `src_en`; pin A enable is control bit 2 and pin B enable is control bit 6.
- R5: Control register layout, per pin (pin A bits 3:0, pin B bits 7:4): bit 0 trigger type (1 edge, 0 level), bit 1 pending flag, bit 2 enable, bit 3 priority (1 high). A byte write (`wr_bit`=0) with address C0h loads all eight bits. Any other byte-write address leaves the register unchanged. A bit write (`wr_bit`=1) with address C0h..C7h writes `wr_data[0]` into the bit given by address bits 2:0.
- R6: In edge mode, a high-to-low transition on the pin sets the pin's pending flag. The flag stays set after the pin returns high, and the pin then requests service.
- R7: When the CPU acknowledges a presented request, `irq_valid` is 0 in the following cycle. If the acknowledged source is an edge-mode pin, that pin's pending flag is cleared.
- R8: In level mode, the pin requests service while it is low and stops once it is high again. Its pending flag mirrors the synchronized low state, and software writes to that flag have no effect.
- R9: While a low-level routine is active, only high-priority requests are presented. While a high-level routine is active, none is presented. Each `reti` pulse ends the innermost active level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control register write strobe |
| wr_bit | input | 1 | 1: single-bit write, 0: byte write |
| wr_addr | input | 8 | Byte or bit address |
| wr_data | input | 8 | Byte data; bit 0 carries the value for bit writes |
| ctl_q | output | 8 | Control register contents |
| glb_en | input | 1 | Global interrupt enable |
| src_req | input | 6 | Request flags of sources 0..5 |
| src_en | input | 6 | Enables of sources 0..5 |
| src_pri | input | 6 | Priority of sources 0..5 (1 high) |
| xpin_n | input | 2 | Pins A (bit 0) and B (bit 1), active low |
| ack | input | 1 | CPU takes the presented request |
| reti | input | 1 | CPU leaves the innermost service routine |
| irq_valid | output | 1 | A request is presented |
| irq_src | output | 3 | Index of the presented source |
| irq_vec | output | 8 | Vector address of the presented source |
| irq_hi | output | 1 | Presented request is high priority |

## Verification
Several corner cases are targeted. In the nesting case, a lower-ranked but higher-level request must break through while a same-level one must not. A design that compared only rank, or that let equal levels preempt, would present the wrong source or present one where none is allowed. The bench checks that an edge flag survives the pin returning high and clears only on acknowledge; a design that latched the pin directly would lose the request or serve it forever. It checks that level mode tracks the pin both ways and ignores flag writes. It also checks that byte writes to neighbouring addresses are ignored, so a decoder that uses only the upper address bits in byte mode would corrupt the register.

// File: rtl/irq8_pkg.sv
`timescale 1ns/1ps
package irq8_pkg;
  // per-pin field offsets inside its 4-bit slice of the control register
  localparam int F_TRIG   = 0;
  localparam int F_FLAG   = 1;
  localparam int F_EN     = 2;
  localparam int F_PRI    = 3;
  localparam int F_STRIDE = 4;
  localparam int VEC_W    = 8;

  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] base,
                                              input logic [VEC_W-1:0] step,
                                              input logic [VEC_W-1:0] idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq8_xsync.sv
`timescale 1ns/1ps
module irq8_xsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall,
  output logic low
);
  // STAGES flops of synchronizer plus one history flop; idle level is high
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[STAGES-1:0], pin_n};
  end

  assign low  = ~sh[STAGES-1];
  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/irq8_xctl.sv
`timescale 1ns/1ps
module irq8_xctl
  import irq8_pkg::*;
#(
  parameter int         N_EXT    = 2,
  parameter logic [7:0] CTL_ADDR = 8'hC0,
  localparam int        CW       = N_EXT * F_STRIDE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [N_EXT-1:0] edge_set,
  input  logic [N_EXT-1:0] ack_clr,
  input  logic [N_EXT-1:0] lvl_low,
  output logic [CW-1:0]    q
);
  localparam int BW = $clog2(CW);
  logic [CW-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr_en) begin
      if (wr_bit && (wr_addr[7:BW] == CTL_ADDR[7:BW]))
        nxt[wr_addr[BW-1:0]] = wr_data[0];
      else if (!wr_bit && (wr_addr == CTL_ADDR))
        nxt = wr_data[CW-1:0];
    end
    for (int k = 0; k < N_EXT; k++) begin
      if (!nxt[k*F_STRIDE + F_TRIG])
        nxt[k*F_STRIDE + F_FLAG] = lvl_low[k];
      else if (edge_set[k])
        nxt[k*F_STRIDE + F_FLAG] = 1'b1;
      else if (ack_clr[k])
        nxt[k*F_STRIDE + F_FLAG] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/irq8_arb.sv
`timescale 1ns/1ps
module irq8_arb #(
  parameter int  N    = 8,
  localparam int ID_W = $clog2(N)
) (
  input  logic [N-1:0]    pend,
  input  logic [N-1:0]    hi,
  input  logic            act_hi,
  input  logic            act_lo,
  output logic            valid,
  output logic [ID_W-1:0] id,
  output logic            lvl
);
  logic [N-1:0] sel;
  logic         pick_hi;

  always_comb begin
    pick_hi = !act_hi && |(pend & hi);
    if (pick_hi)                sel = pend & hi;
    else if (!act_hi && !act_lo) sel = pend & ~hi;
    else                        sel = '0;
    valid = |sel;
    lvl   = pick_hi;
    id    = '0;
    for (int i = N - 1; i >= 0; i--)
      if (sel[i]) id = ID_W'(i);
  end
endmodule

// File: rtl/irq8_ctrl.sv
`timescale 1ns/1ps
module irq8_ctrl
  import irq8_pkg::*;
#(
  parameter int         N_STD       = 6,
  parameter int         N_EXT       = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CTL_ADDR    = 8'hC0,
  parameter logic [7:0] VEC_BASE    = 8'h03,
  parameter logic [7:0] VEC_STEP    = 8'h08,
  localparam int        N_SRC       = N_STD + N_EXT,
  localparam int        ID_W        = $clog2(N_SRC),
  localparam int        CW          = N_EXT * F_STRIDE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [CW-1:0]    ctl_q,
  input  logic             glb_en,
  input  logic [N_STD-1:0] src_req,
  input  logic [N_STD-1:0] src_en,
  input  logic [N_STD-1:0] src_pri,
  input  logic [N_EXT-1:0] xpin_n,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_valid,
  output logic [ID_W-1:0]  irq_src,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_hi
);
  logic [N_EXT-1:0] x_fall, x_low, x_req, x_en, x_pri, x_edge_set, x_ack_clr;
  logic [N_SRC-1:0] pend, pri;
  logic             arb_valid, arb_lvl, ack_take;
  logic [ID_W-1:0]  arb_id;
  logic             act_hi, act_lo;

  assign ack_take = ack && irq_valid;

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    irq8_xsync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst  (rst),
      .pin_n(xpin_n[k]),
      .fall (x_fall[k]),
      .low  (x_low[k])
    );
    assign x_edge_set[k] = x_fall[k] && ctl_q[k*F_STRIDE + F_TRIG];
    assign x_ack_clr[k]  = ack_take && (irq_src == ID_W'(N_STD + k));
    assign x_req[k]      = ctl_q[k*F_STRIDE + F_TRIG] ? ctl_q[k*F_STRIDE + F_FLAG]
                                                      : x_low[k];
    assign x_en[k]       = ctl_q[k*F_STRIDE + F_EN];
    assign x_pri[k]      = ctl_q[k*F_STRIDE + F_PRI];
  end

  irq8_xctl #(.N_EXT(N_EXT), .CTL_ADDR(CTL_ADDR)) i_xctl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_bit  (wr_bit),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .edge_set(x_edge_set),
    .ack_clr (x_ack_clr),
    .lvl_low (x_low),
    .q       (ctl_q)
  );

  assign pend = {x_req & x_en, src_req & src_en} & {N_SRC{glb_en}};
  assign pri  = {x_pri, src_pri};

  irq8_arb #(.N(N_SRC)) i_arb (
    .pend  (pend),
    .hi    (pri),
    .act_hi(act_hi),
    .act_lo(act_lo),
    .valid (arb_valid),
    .id    (arb_id),
    .lvl   (arb_lvl)
  );

  // in-service record: reti pops the innermost level, an accepted ack pushes
  always_ff @(posedge clk) begin
    if (rst) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      if (reti) begin
        if (act_hi) act_hi <= 1'b0;
        else        act_lo <= 1'b0;
      end
      if (ack_take) begin
        if (irq_hi) act_hi <= 1'b1;
        else        act_lo <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ack_take) begin
      irq_valid <= 1'b0;
      irq_src   <= '0;
      irq_vec   <= '0;
      irq_hi    <= 1'b0;
    end else begin
      irq_valid <= arb_valid;
      irq_src   <= arb_id;
      irq_vec   <= arb_valid ? vec_of(VEC_BASE, VEC_STEP, VEC_W'(arb_id)) : '0;
      irq_hi    <= arb_valid && arb_lvl;
    end
  end
endmodule

// File: rtl/irq8_ctrl_chk.sv
`timescale 1ns/1ps
module irq8_ctrl_chk #(
  parameter int         ID_W     = 3,
  parameter int         CW       = 8,
  parameter logic [7:0] VEC_BASE = 8'h03,
  parameter logic [7:0] VEC_STEP = 8'h08
) (
  input logic            clk,
  input logic            rst,
  input logic            glb_en,
  input logic            ack,
  input logic            wr_en,
  input logic            act_hi,
  input logic [CW-1:0]   ctl_q,
  input logic            irq_valid,
  input logic [ID_W-1:0] irq_src,
  input logic [7:0]      irq_vec
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  p_reset_clear_r1: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (!irq_valid && ctl_q == '0));

  p_vector_map_r2: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> (irq_vec == VEC_BASE + VEC_STEP * 8'(irq_src)));

  p_global_gate_r4: assert property (@(posedge clk) disable iff (rst)
    $past(!glb_en) |-> !irq_valid);

  p_flag_hold_a_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] && ctl_q[1]) |=> (ctl_q[1] || $past(ack) || $past(wr_en)));

  p_flag_hold_b_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[4] && ctl_q[5]) |=> (ctl_q[5] || $past(ack) || $past(wr_en)));

  p_ack_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (ack && irq_valid) |=> !irq_valid);

  p_high_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    act_hi |-> !irq_valid);
endmodule

bind irq8_ctrl irq8_ctrl_chk #(
  .ID_W(ID_W), .CW(CW), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) i_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .ack(ack), .wr_en(wr_en),
  .act_hi(act_hi), .ctl_q(ctl_q), .irq_valid(irq_valid),
  .irq_src(irq_src), .irq_vec(irq_vec)
);

// File: tb/test_irq8_ctrl.sv
`timescale 1ns/1ps
module test_irq8_ctrl;
  logic       clk = 1'b0;
  logic       rst, wr_en, wr_bit, glb_en, ack, reti;
  logic [7:0] wr_addr, wr_data, ctl_q, irq_vec;
  logic [5:0] src_req, src_en, src_pri;
  logic [1:0] xpin_n;
  logic       irq_valid, irq_hi;
  logic [2:0] irq_src;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  irq8_ctrl i_irq8_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bit(wr_bit), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl_q(ctl_q), .glb_en(glb_en), .src_req(src_req),
    .src_en(src_en), .src_pri(src_pri), .xpin_n(xpin_n), .ack(ack), .reti(reti),
    .irq_valid(irq_valid), .irq_src(irq_src), .irq_vec(irq_vec), .irq_hi(irq_hi)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_bit = 1'b0; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic wr_one(input logic [7:0] a, input logic v);
    wr_en = 1'b1; wr_bit = 1'b1; wr_addr = a; wr_data = {7'd0, v};
    tick(1);
    wr_en = 1'b0; wr_bit = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1; tick(1); ack = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(1); reti = 1'b0;
  endtask

  // {valid, id}: expected winner from requirements R3 and R9
  function automatic logic [3:0] pick(input logic [7:0] pend, input logic [7:0] pri,
                                      input logic ah, input logic al);
    logic [7:0] s;
    logic [2:0] id;
    s = 8'd0; id = 3'd0;
    if (!ah && |(pend & pri))  s = pend & pri;
    else if (!ah && !al)       s = pend & ~pri;
    for (int i = 7; i >= 0; i--) if (s[i]) id = 3'(i);
    return {|s, id};
  endfunction

  task automatic expect_irq(input string tag, input logic v, input logic [2:0] id);
    check({tag, " valid"}, 32'(irq_valid), 32'(v));
    if (v) begin
      check({tag, " source"}, 32'(irq_src), 32'(id));
      check({tag, " vector R2"}, 32'(irq_vec), 32'(8'h03 + 8'(id) * 8'h08));
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, pend, pri;
    logic [3:0] e;
    void'($urandom(32'h1F2E3D4C));
    rst = 1'b1; wr_en = 1'b0; wr_bit = 1'b0; wr_addr = 8'h00; wr_data = 8'h00;
    glb_en = 1'b0; ack = 1'b0; reti = 1'b0;
    src_req = '0; src_en = '0; src_pri = '0; xpin_n = 2'b11;
    tick(3);
    check("R1 ctl during reset", 32'(ctl_q), 0);
    check("R1 valid during reset", 32'(irq_valid), 0);
    rst = 1'b0;
    tick(1);
    check("R1 ctl after reset", 32'(ctl_q), 0);
    check("R1 valid after reset", 32'(irq_valid), 0);

    // random arbitration: both pins in edge mode so flag writes stick (R3 R4 R5)
    for (int n = 0; n < 60; n++) begin
      d = 8'($urandom); d[0] = 1'b1; d[4] = 1'b1;
      wr_byte(8'hC0, d);
      src_req = 6'($urandom); src_en = 6'($urandom); src_pri = 6'($urandom);
      glb_en  = ($urandom % 4) != 0;
      tick(2);
      pend = {d[5] & d[6], d[1] & d[2], src_req & src_en} & {8{glb_en}};
      pri  = {d[7], d[3], src_pri};
      e = pick(pend, pri, 1'b0, 1'b0);
      check("R5 byte write random", 32'(ctl_q), 32'(d));
      expect_irq("R3 R4 random", e[3], e[2:0]);
      if (e[3]) check("R3 level random", 32'(irq_hi), 32'(pri[e[2:0]]));
    end

    // R5 bit writes and ignored byte address
    glb_en = 1'b1; src_req = '0; src_en = '0; src_pri = '0;
    wr_byte(8'hC0, 8'h11);
    wr_one(8'hC2, 1'b1);
    check("R5 bit write C2", 32'(ctl_q), 32'h15);
    wr_one(8'hC7, 1'b1);
    check("R5 bit write C7", 32'(ctl_q), 32'h95);
    wr_one(8'hC2, 1'b0);
    check("R5 bit clear C2", 32'(ctl_q), 32'h91);
    wr_byte(8'hC1, 8'hFF);
    check("R5 byte write elsewhere ignored", 32'(ctl_q), 32'h91);
    wr_byte(8'hC0, 8'h11);

    // R3 directed: high pin B beats all low sources; high timer 2 beats low rest
    src_en = 6'h3F; src_req = 6'h3F;
    wr_byte(8'hC0, 8'hF1);
    tick(2);
    expect_irq("R3 high pin B wins", 1'b1, 3'd7);
    check("R3 irq_hi", 32'(irq_hi), 1);
    wr_byte(8'hC0, 8'h11);
    src_pri = 6'h20;
    tick(2);
    expect_irq("R3 high timer2 wins", 1'b1, 3'd5);
    src_pri = 6'h00;
    tick(2);
    expect_irq("R3 rank order", 1'b1, 3'd0);
    src_req = '0;

    // R6 edge mode on pin A, then R7 acknowledge
    wr_byte(8'hC0, 8'h15);
    xpin_n[0] = 1'b0; tick(5);
    check("R6 flag set on fall", 32'(ctl_q[1]), 1);
    xpin_n[0] = 1'b1; tick(5);
    check("R6 flag holds after rise", 32'(ctl_q[1]), 1);
    expect_irq("R6 pin A requests", 1'b1, 3'd6);
    pulse_ack();
    check("R7 valid drops after ack", 32'(irq_valid), 0);
    check("R7 flag cleared by ack", 32'(ctl_q[1]), 0);
    tick(2);
    check("R7 no re-request", 32'(irq_valid), 0);
    pulse_reti();

    // R8 level mode on pin B, R4 global gate
    wr_byte(8'hC0, 8'h41);
    xpin_n[1] = 1'b0; tick(5);
    expect_irq("R8 level low requests", 1'b1, 3'd7);
    check("R8 flag mirrors low", 32'(ctl_q[5]), 1);
    glb_en = 1'b0; tick(2);
    check("R4 global disable", 32'(irq_valid), 0);
    glb_en = 1'b1;
    xpin_n[1] = 1'b1; tick(5);
    check("R8 released pin", 32'(irq_valid), 0);
    check("R8 flag mirrors high", 32'(ctl_q[5]), 0);
    wr_one(8'hC5, 1'b1);
    check("R8 flag write ignored", 32'(ctl_q[5]), 0);
    wr_byte(8'hC0, 8'h11);

    // R9 nesting
    src_en = 6'h3F; src_pri = 6'h00; src_req = 6'h10;
    tick(2);
    expect_irq("R9 serial low", 1'b1, 3'd4);
    pulse_ack();
    src_req = 6'h12; tick(3);
    check("R9 same level blocked", 32'(irq_valid), 0);
    src_pri = 6'h02; tick(2);
    expect_irq("R9 high preempts low", 1'b1, 3'd1);
    pulse_ack();
    tick(2);
    check("R9 nothing over high", 32'(irq_valid), 0);
    pulse_reti();
    tick(2);
    expect_irq("R9 pop high leaves low", 1'b1, 3'd1);
    src_req = 6'h10; src_pri = 6'h00; tick(2);
    check("R9 low still active", 32'(irq_valid), 0);
    pulse_reti();
    tick(2);
    expect_irq("R9 pop low", 1'b1, 3'd4);
    src_req = '0;
    tick(2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule